// File: doc/BRIEF.md
# NFC-F Frame Transmitter with Manchester Chip Output

This block assembles one outgoing NFC-F frame and shifts it out as a Manchester chip stream for an external modulator. Software or a neighbouring block first fills a payload buffer through a byte write port. It then presents the frame length value and an optional absolute start time, and pulses `start`. The transmitter sends six zero bytes as a lead-in. These are followed by the two-byte sync word, the length byte and the payload bytes. Next comes a CRC-16 that the block computes on the fly, and last come two zero guard bytes. It then reports completion with a one-cycle `done` pulse.

The length value L counts the length byte itself plus the payload, so L-1 payload bytes are read from buffer addresses 0 upward. If `start_at` is nonzero, the transmitter parks in a wait state until the external free-running `tick_count` equals that value. A zero `start_at` starts the frame at once. `rate_fast` chooses between two chip periods and changes nothing else.

The control is a single state machine. Its states are:
- IDLE: waiting for a start request.
- WAIT: holding for the start time.
- PRE: lead-in zeros.
- SYNC1 and SYNC2: the two sync bytes.
- LEN: the length byte.
- DATA: the payload bytes.
- CRC1 and CRC2: the checksum bytes.
- GUARD: the guard zeros.
- DRAIN: the final byte finishing its chips.
- DONE: the one-cycle completion state.

Its transitions are:
- IDLE to WAIT, or IDLE to PRE, on an accepted start.
- WAIT to PRE when the tick matches.
- Each sending state moves on once its last byte has been handed to the serializer.
- LEN goes straight to CRC1 when L is 1.
- GUARD moves to DRAIN.
- DRAIN moves to DONE after the last chip.
- DONE returns to IDLE.

Top module: `nfcf_frame_tx`

## Requirements
- R1: After reset, `busy`, `done`, `chip_en` and `chip_out` are all 0.
- R2: A frame carries these bytes in this order: 6 bytes of 0x00, then 0xB2, 0x4D, then the length value L, then the L-1 payload bytes from buffer addresses 0 upward, then two CRC bytes, then 2 bytes of 0x00. That makes 6+L+4+2 bytes in total.
- R3: The CRC is CRC-16 with polynomial 0x1021 and initial value 0x0000, not reflected. It is taken over the length byte and the payload, and it is sent high byte first.
- R4: Each bit becomes two chips, most significant bit of each byte first. A 1 bit is chip 1 then chip 0, and a 0 bit is chip 0 then chip 1. A chip lasts CHIP_CYC_SLOW clocks when `rate_fast` was 0 at the accepted start, and CHIP_CYC_FAST clocks when it was 1. `chip_en` is high for every chip of the frame without gaps.
- R5: With a nonzero `start_at`, no chip is sent before `tick_count` equals `start_at`. The first chip appears in the second clock after the edge where they match. With `start_at` of 0, the first chip appears in the second clock after the edge that accepted the start.
- R6: `busy` rises in the clock after an accepted start and stays high through the last guard chip. In the following clock, `done` is 1 for exactly one cycle while `busy` and `chip_en` are 0.
- R7: A `start` pulse while `busy` is high is ignored. The frame in flight is unchanged, and no second frame follows it.
- R8: A `start` with a length value of 0 is ignored. `busy` stays low and no chip is sent.
- R9: With `wr_en` high, `wr_data` is stored at `wr_addr` in the payload buffer, and it is the byte later sent for that payload position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Payload buffer write enable |
| wr_addr | input | AW | Payload buffer write address |
| wr_data | input | 8 | Payload byte to store |
| frame_len | input | 8 | Length value L (length byte plus payload count) |
| start | input | 1 | Start request strobe |
| start_at | input | TICK_W | Absolute start tick, 0 for immediate |
| tick_count | input | TICK_W | External free-running tick counter |
| rate_fast | input | 1 | Selects the short chip period |
| chip_out | output | 1 | Manchester chip stream |
| chip_en | output | 1 | High while a chip is being sent |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the transmitter with a six-byte payload buffer, chip periods of 4 and 2 clocks, and a 16-bit tick. With these values, every legal length from 1 to 7 can be sent at both rates in a few thousand cycles. This covers the bypass of the empty payload and the full buffer. Odd lengths use a delayed start time and even lengths an immediate one, so both start paths are crossed with every rate. Each frame is decoded chip by chip against an arithmetically computed byte list and CRC. A stray start is injected mid-frame.

// File: rtl/nfcf_tx_pkg.sv
package nfcf_tx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_SYNC1,
        ST_SYNC2,
        ST_LEN,
        ST_DATA,
        ST_CRC1,
        ST_CRC2,
        ST_GUARD,
        ST_DRAIN,
        ST_DONE
    } tx_state_t;

    localparam logic [7:0]  SYNC_FIRST  = 8'hB2;
    localparam logic [7:0]  SYNC_SECOND = 8'h4D;
    localparam logic [15:0] CRC_POLY    = 16'h1021;

    // one byte through the CRC, byte-xor form, MSB first
    function automatic logic [15:0] crc16_byte(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] r;
        r = cur ^ {din, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/nfcf_crc16.sv
module nfcf_crc16
    import nfcf_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= 16'h0000;
        end else if (clr) begin
            crc <= 16'h0000;
        end else if (en) begin
            crc <= crc16_byte(crc, din);
        end
    end

    AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc == 16'h0000)); // R3

endmodule

// File: rtl/nfcf_payload_buf.sv
module nfcf_payload_buf #(
    parameter int DEPTH = 254,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [7:0]    rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (int'(rd_addr) < DEPTH) begin
            rd_data = mem[rd_addr[AW-1:0]];
        end else begin
            rd_data = 8'h00;
        end
    end

endmodule

// File: rtl/nfcf_manch_ser.sv
module nfcf_manch_ser #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [7:0]    byte_in,
    input  logic [CW-1:0] period,
    output logic          chip,
    output logic          active,
    output logic          last
);

    logic [7:0]    sh_q;
    logic          half_q;
    logic [2:0]    bit_q;
    logic [CW-1:0] tick_q;
    logic          act_q;
    logic          wrap;

    assign wrap   = (tick_q == (period - 1'b1));
    assign last   = act_q && wrap && half_q && (bit_q == 3'd7);
    assign active = act_q;
    assign chip   = act_q & (sh_q[7] ^ half_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= 8'h00;
            half_q <= 1'b0;
            bit_q  <= 3'd0;
            tick_q <= '0;
            act_q  <= 1'b0;
        end else if (load) begin
            sh_q   <= byte_in;
            half_q <= 1'b0;
            bit_q  <= 3'd0;
            tick_q <= '0;
            act_q  <= 1'b1;
        end else if (act_q) begin
            if (wrap) begin
                tick_q <= '0;
                if (half_q) begin
                    half_q <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    bit_q  <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        act_q <= 1'b0;
                    end
                end else begin
                    half_q <= 1'b1;
                end
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    AST_MID_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && wrap && !half_q && !load) |=> (chip != $past(chip))); // R4

    AST_CHIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !wrap && !load) |=> $stable(chip)); // R4

endmodule

// File: rtl/nfcf_frame_tx.sv
module nfcf_frame_tx
    import nfcf_tx_pkg::*;
#(
    parameter int BUF_DEPTH     = 254,
    parameter int TICK_W        = 32,
    parameter int CHIP_CYC_SLOW = 32,
    parameter int CHIP_CYC_FAST = 16,
    parameter int PRE_BYTES     = 6,
    parameter int GUARD_BYTES   = 2,
    localparam int AW      = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int CYC_MAX = (CHIP_CYC_SLOW > CHIP_CYC_FAST) ? CHIP_CYC_SLOW : CHIP_CYC_FAST,
    localparam int CW      = $clog2(CYC_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        frame_len,
    input  logic              start,
    input  logic [TICK_W-1:0] start_at,
    input  logic [TICK_W-1:0] tick_count,
    input  logic              rate_fast,
    output logic              chip_out,
    output logic              chip_en,
    output logic              busy,
    output logic              done
);

    localparam logic [7:0] PRE_LAST   = 8'(PRE_BYTES - 1);
    localparam logic [7:0] GUARD_LAST = 8'(GUARD_BYTES - 1);

    tx_state_t         state_q, state_d;
    logic [7:0]        cnt_q;
    logic [7:0]        len_q;
    logic [TICK_W-1:0] at_q;
    logic [CW-1:0]     period_q;

    logic        accept;
    logic        ser_load, ser_active, ser_last, ser_ready;
    logic [7:0]  ser_byte;
    logic        crc_en;
    logic [15:0] crc_val;
    logic [7:0]  pay_byte;

    assign accept    = (state_q == ST_IDLE) && start && (frame_len != 8'd0);
    assign ser_ready = !ser_active || ser_last;

    nfcf_payload_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (cnt_q),
        .rd_data (pay_byte)
    );

    nfcf_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (crc_en),
        .din   (ser_byte),
        .crc   (crc_val)
    );

    nfcf_manch_ser #(.CW(CW)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ser_load),
        .byte_in (ser_byte),
        .period  (period_q),
        .chip    (chip_out),
        .active  (ser_active),
        .last    (ser_last)
    );

    // state register and frame context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= 8'd0;
            len_q    <= 8'd0;
            at_q     <= '0;
            period_q <= CW'(CHIP_CYC_SLOW);
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= 8'd0;
            end else if (ser_load) begin
                cnt_q <= cnt_q + 8'd1;
            end
            if (accept) begin
                len_q    <= frame_len;
                at_q     <= start_at;
                period_q <= rate_fast ? CW'(CHIP_CYC_FAST) : CW'(CHIP_CYC_SLOW);
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (start_at != '0) ? ST_WAIT : ST_PRE;
            ST_WAIT:  if (tick_count == at_q) state_d = ST_PRE;
            ST_PRE:   if (ser_ready && cnt_q == PRE_LAST) state_d = ST_SYNC1;
            ST_SYNC1: if (ser_ready) state_d = ST_SYNC2;
            ST_SYNC2: if (ser_ready) state_d = ST_LEN;
            ST_LEN:   if (ser_ready) state_d = (len_q == 8'd1) ? ST_CRC1 : ST_DATA;
            ST_DATA:  if (ser_ready && cnt_q == (len_q - 8'd2)) state_d = ST_CRC1;
            ST_CRC1:  if (ser_ready) state_d = ST_CRC2;
            ST_CRC2:  if (ser_ready) state_d = ST_GUARD;
            ST_GUARD: if (ser_ready && cnt_q == GUARD_LAST) state_d = ST_DRAIN;
            ST_DRAIN: if (ser_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and byte selection
    always_comb begin
        ser_load = 1'b0;
        ser_byte = 8'h00;
        crc_en   = 1'b0;
        unique case (state_q)
            ST_PRE:   begin ser_load = ser_ready; ser_byte = 8'h00; end
            ST_SYNC1: begin ser_load = ser_ready; ser_byte = SYNC_FIRST; end
            ST_SYNC2: begin ser_load = ser_ready; ser_byte = SYNC_SECOND; end
            ST_LEN:   begin ser_load = ser_ready; ser_byte = len_q;    crc_en = ser_ready; end
            ST_DATA:  begin ser_load = ser_ready; ser_byte = pay_byte; crc_en = ser_ready; end
            ST_CRC1:  begin ser_load = ser_ready; ser_byte = crc_val[15:8]; end
            ST_CRC2:  begin ser_load = ser_ready; ser_byte = crc_val[7:0]; end
            ST_GUARD: begin ser_load = ser_ready; ser_byte = 8'h00; end
            default:  begin ser_load = 1'b0; ser_byte = 8'h00; end
        endcase
    end

    assign chip_en = ser_active;
    assign busy    = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done    = (state_q == ST_DONE);

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !chip_en)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !chip_en); // R6

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !chip_en); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_q)); // R7

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && frame_len == 8'd0) |=> !busy); // R8

endmodule

// File: tb/nfcf_frame_tx_test.sv
module nfcf_frame_tx_test;

    localparam int DEPTH = 6;
    localparam int CS    = 4;
    localparam int CF    = 2;
    localparam int TW    = 16;
    localparam int AW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    frame_len = 8'h00;
    logic          start = 1'b0;
    logic [TW-1:0] start_at = '0;
    logic [TW-1:0] tick = 16'd1;
    logic          rate_fast = 1'b0;
    logic          chip_out, chip_en, busy, done;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;
    always @(posedge clk) tick <= tick + 16'd1;

    nfcf_frame_tx #(
        .BUF_DEPTH(DEPTH), .TICK_W(TW), .CHIP_CYC_SLOW(CS), .CHIP_CYC_FAST(CF),
        .PRE_BYTES(6), .GUARD_BYTES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_len(frame_len), .start(start), .start_at(start_at), .tick_count(tick),
        .rate_fast(rate_fast), .chip_out(chip_out), .chip_en(chip_en), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] b [32], input int first, input int n);
        logic [15:0] c = 16'h0000;
        for (int k = 0; k < n; k++) begin
            for (int j = 7; j >= 0; j--) begin
                logic fb;
                fb = c[15] ^ b[first + k][j];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    logic samp [4096];

    task automatic run_frame(input int len, input bit fast, input bit delayed);
        logic [7:0] exp_b [32];
        logic [15:0] crc;
        int n_exp, div, ns, first_cyc, done_cyc, at_val;
        logic [TW-1:0] first_tick;
        bit prev_en, busy_gap, got_first;
        int data_bad, crc_bad, manch_bad, bad_act, bad_exp;

        // R9: fill the payload buffer
        for (int i = 0; i < len - 1; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = AW'(i);
            wr_data = 8'((i * 37 + len * 11 + (fast ? 5 : 0) + 1) & 255);
        end
        @(negedge clk);
        wr_en = 1'b0;

        for (int i = 0; i < 32; i++) exp_b[i] = 8'h00;
        exp_b[6] = 8'hB2;
        exp_b[7] = 8'h4D;
        exp_b[8] = 8'(len);
        for (int i = 0; i < len - 1; i++)
            exp_b[9 + i] = 8'((i * 37 + len * 11 + (fast ? 5 : 0) + 1) & 255);
        crc = ref_crc(exp_b, 8, len);
        exp_b[8 + len] = crc[15:8];
        exp_b[9 + len] = crc[7:0];
        n_exp = 6 + len + 4 + 2;
        div = fast ? CF : CS;

        @(negedge clk);
        at_val    = delayed ? int'(tick) + 40 : 0;
        frame_len = 8'(len);
        start_at  = TW'(at_val);
        rate_fast = fast;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rate_fast = ~fast;
        check(busy == 1'b1 && chip_en == 1'b0, "R6 busy after start", int'(busy), 1);

        ns = 0; got_first = 0; prev_en = 0; busy_gap = 0; done_cyc = -1;
        first_cyc = -1; first_tick = '0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            if (cyc == 60) begin
                frame_len = 8'd3; start_at = '0; start = 1'b1;   // R7 stray start
            end else begin
                start = 1'b0;
            end
            if (chip_en) begin
                if (!got_first) begin
                    got_first = 1; first_cyc = cyc; first_tick = tick;
                end
                if (ns < 4096) samp[ns] = chip_out;
                ns++;
                if (!busy) busy_gap = 1;
            end else if (got_first && !done) begin
                busy_gap = 1;
            end
            if (done) begin
                done_cyc = cyc;
                check(prev_en && !busy && !chip_en, "R6 done after last chip",
                      int'(prev_en), 1);
                break;
            end
            prev_en = chip_en;
        end
        start = 1'b0;

        check(done_cyc >= 0, "R6 done seen", done_cyc, 1);
        check(!busy_gap, "R4 chip_en contiguous with busy", int'(busy_gap), 0);
        if (delayed)
            check(first_tick == TW'(at_val + 2), "R5 delayed first chip tick",
                  int'(first_tick), at_val + 2);
        else
            check(first_cyc == 0, "R5 immediate first chip cycle", first_cyc, 0);
        check(ns == n_exp * 16 * div, "R4 R2 chip count", ns, n_exp * 16 * div);

        data_bad = 0; crc_bad = 0; manch_bad = 0; bad_act = 0; bad_exp = 0;
        if (ns == n_exp * 16 * div) begin
            for (int b = 0; b < n_exp; b++) begin
                logic [7:0] got;
                got = 8'h00;
                for (int j = 0; j < 8; j++) begin
                    int base;
                    logic a, c;
                    base = (b * 8 + j) * 2 * div;
                    a = samp[base];
                    c = samp[base + div];
                    for (int t = 1; t < div; t++) begin
                        if (samp[base + t] != a || samp[base + div + t] != c) manch_bad++;
                    end
                    if (a == c) manch_bad++;
                    got[7 - j] = a;
                end
                if (got != exp_b[b]) begin
                    if (b == 8 + len || b == 9 + len) crc_bad++;
                    else data_bad++;
                    if (bad_act == 0 && bad_exp == 0) begin
                        bad_act = int'(got); bad_exp = int'(exp_b[b]);
                    end
                end
            end
        end
        check(manch_bad == 0, "R4 Manchester pairs", manch_bad, 0);
        check(data_bad == 0, "R2 R9 frame bytes", bad_act, bad_exp);
        check(crc_bad == 0, "R3 CRC bytes", bad_act, bad_exp);

        @(negedge clk);
        check(!done && !busy, "R6 single done pulse", int'(done), 0);
        begin
            bit extra;
            extra = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (busy || chip_en) extra = 1;
            end
            check(!extra, "R7 no frame from stray start", int'(extra), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !chip_en && !chip_out, "R1 reset outputs",
              int'({busy, done, chip_en, chip_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !chip_en && !chip_out, "R1 after release",
              int'({busy, done, chip_en, chip_out}), 0);

        // R8: zero length ignored
        frame_len = 8'd0; start_at = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            bit seen;
            seen = 0;
            for (int k = 0; k < 20; k++) begin
                if (busy || chip_en) seen = 1;
                @(negedge clk);
            end
            check(!seen, "R8 zero length ignored", int'(seen), 0);
        end

        for (int r = 0; r < 2; r++) begin
            for (int l = 1; l <= DEPTH + 1; l++) begin
                run_frame(l, r[0], l[0]);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule